// File: doc/BRIEF.md
# Two-Stage Complex Decimate-by-32 Filter

This block takes a complex baseband stream (I and Q, 16-bit signed) at the converter rate and brings it down by a factor of 32. The rate is reduced in two cascaded lowpass stages: a 16-tap stage that keeps one output in 4 and a 32-tap stage that keeps one output in 8. An 80 MS/s input therefore leaves as 2.5 MS/s, wide enough for a 2 MHz signal centred at zero. Both stages are polyphase. A stage computes only the outputs it keeps. Each input sample feeds the subfilter chosen by its position in the current block of M inputs, and the partial sums collect in a short row of accumulators. The coefficients are fixed, symmetric, equiripple-style constants held in the package as Q1.15 values. I and Q share them.

Both ends of the block are valid/ready streams. A transfer happens on a rising clock edge when valid and ready are both high. Input ready is high whenever the output register is empty or is being emptied in the same cycle. When the consumer holds the output back, the block stops taking input. It does not buffer, so back-pressure travels straight to the source. An output word stays on the pins, unchanged, until it is taken. A synchronous reset clears every accumulator and every phase counter, so output 0 after reset is always computed from input samples 0 to 31.

Top module: `iq_decim32`

## Requirements
- R1: While reset is high and in the first cycle after it is released, m_valid is 0, and s_ready is 1 once reset is low.
- R2: Exactly one output transfer happens for each 32 accepted input transfers. Output k (counted from 0 after reset) appears only after input 32k+31 has been accepted. No extra outputs appear while the input is idle.
- R3: With input samples x[n] numbered from 0 after reset, and x[n]=0 for n<0, stage one forms y1[m] = S(sum over j=0..15 of h1[j]·x[4m+3−j]). The output is then S(sum over j=0..31 of h2[j]·y1[8k+7−j]). The taps h1 and h2 are the package constants, symmetric about their centre.
- R4: The rounding S(a) is (a + 2^14) shifted right arithmetically by 15 bits, which rounds to nearest with ties going up. It is applied at the output of each stage.
- R5: Each stage output saturates to the range −32768..32767, including for full-scale DC input of either sign.
- R6: The Q path is filtered with the same taps as the I path, independently of it: output Q depends only on input Q.
- R7: s_ready equals (not m_valid) or m_ready in every cycle after reset.
- R8: While m_valid is 1 and m_ready is 0, m_valid, m_i and m_q hold their values into the next cycle.
- R9: A reset in the middle of a stream discards all history: the outputs that follow depend only on samples accepted after the reset.
- R10: A cycle with s_valid low, or with s_ready low, has no effect on the result, whatever values are on s_i and s_q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample present |
| s_ready | output | 1 | Block can take an input sample this cycle |
| s_i | input | 16 | Input in-phase sample, signed |
| s_q | input | 16 | Input quadrature sample, signed |
| m_valid | output | 1 | Output sample present |
| m_ready | input | 1 | Consumer takes the output sample this cycle |
| m_i | output | 16 | Output in-phase sample, signed |
| m_q | output | 16 | Output quadrature sample, signed |

## Verification
The hardest states to reach from the ports are those deep inside the chain. One is saturation at the first stage's output, which the second stage then has to carry. Another is a consumer stall that lands on the very cycle the 32nd input of a block would be taken. The bench drives full-scale DC of both signs to force the first case, and full-scale square waves to push the second stage into its limits. It sweeps a unit impulse over every phase position of a 32-sample block, so that every tap of both stages and every commutator phase shows up in an output. Random input gaps and random consumer stalls, with garbage on idle data pins, cover the stall cases. A reset issued halfway through a block, while accumulators are loaded, shows that no history survives it.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int DATA_W    = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;
  localparam int S1_DECIM  = 4;
  localparam int S1_TAPS   = 16;
  localparam int S2_DECIM  = 8;
  localparam int S2_TAPS   = 32;

  // First half of each symmetric tap set, Q1.15; second half is mirrored.
  localparam int S1_HALF [8]  = '{-100, -220, 0, 760, 2000, 3600, 4950, 5700};
  localparam int S2_HALF [16] = '{-67, -100, -118, -84, 0, 151, 370, 639,
                                  941, 1277, 1613, 1932, 2201, 2419, 2554, 2621};

  // Tap value of a stage at position idx; zero outside the filter span.
  function automatic int tap_coef(input int stage, input int idx);
    int h;
    int r;
    r = 0;
    if (stage == 1) begin
      if (idx >= 0 && idx < S1_TAPS) begin
        h = (idx < S1_TAPS / 2) ? idx : S1_TAPS - 1 - idx;
        r = S1_HALF[h[2:0]];
      end
    end else begin
      if (idx >= 0 && idx < S2_TAPS) begin
        h = (idx < S2_TAPS / 2) ? idx : S2_TAPS - 1 - idx;
        r = S2_HALF[h[3:0]];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/decim_lane.sv
// One channel of one polyphase stage, transposed form: K partial sums,
// each belonging to an output that is 0..K-1 blocks away.
module decim_lane
  import decim_pkg::*;
#(
  parameter int M     = 4,
  parameter int TAPS  = 16,
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 15,
  parameter int STAGE = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic [$clog2(M)-1:0]       phase,
  input  logic                       last,
  input  logic signed [W-1:0]        x,
  output logic signed [W-1:0]        y
);
  localparam int K  = TAPS / M;
  localparam int PW = W + CW;
  localparam int AW = PW + $clog2(K) + 2;
  localparam logic signed [AW-1:0] HALF = AW'(longint'(1) << (FRAC - 1));
  localparam logic signed [AW-1:0] YMAX = AW'((longint'(1) << (W - 1)) - 1);
  localparam logic signed [AW-1:0] YMIN = ~YMAX;

  logic signed [AW-1:0] acc  [K];
  logic signed [PW-1:0] prod [K];
  logic signed [AW-1:0] total, rnd;
  logic signed [W-1:0]  ysat;

  // Subfilter selected by phase: accumulator i takes tap (M-1-phase)+i*M.
  always_comb begin
    for (int i = 0; i < K; i++) begin
      logic signed [CW-1:0] c;
      c = CW'(tap_coef(STAGE, (M - 1 - int'(phase)) + i * M));
      prod[i] = PW'(c) * PW'(x);
    end
  end

  always_comb begin
    total = acc[0] + AW'(prod[0]);
    rnd   = (total + HALF) >>> FRAC;
    if (rnd > YMAX)      ysat = YMAX[W-1:0];
    else if (rnd < YMIN) ysat = YMIN[W-1:0];
    else                 ysat = rnd[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K; i++) acc[i] <= '0;
      y <= '0;
    end else if (step) begin
      if (last) begin
        y <= ysat;
        for (int i = 0; i < K - 1; i++) acc[i] <= acc[i + 1] + AW'(prod[i + 1]);
        acc[K-1] <= '0;
      end else begin
        for (int i = 0; i < K; i++) acc[i] <= acc[i] + AW'(prod[i]);
      end
    end
  end
endmodule

// File: rtl/polyphase_decim.sv
// One decimating stage: commutator phase counter plus an I and a Q lane.
module polyphase_decim
  import decim_pkg::*;
#(
  parameter int M     = 4,
  parameter int TAPS  = 16,
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 15,
  parameter int STAGE = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam int PHW   = $clog2(M);
  localparam int NCHAN = 2;

  logic [PHW-1:0]      phase;
  logic                last;
  logic signed [W-1:0] xin  [NCHAN];
  logic signed [W-1:0] yout [NCHAN];

  assign last   = (phase == PHW'(M - 1));
  assign xin[0] = in_i;
  assign xin[1] = in_q;
  assign out_i  = yout[0];
  assign out_q  = yout[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && last;
      if (in_valid) phase <= last ? '0 : phase + 1'b1;
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_lane
    decim_lane #(
      .M(M), .TAPS(TAPS), .W(W), .CW(CW), .FRAC(FRAC), .STAGE(STAGE)
    ) lane_i (
      .clk(clk), .rst(rst), .step(in_valid), .phase(phase), .last(last),
      .x(xin[c]), .y(yout[c])
    );
  end
endmodule

// File: rtl/iq_decim32.sv
module iq_decim32
  import decim_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int CW    = COEF_W,
  parameter int FRAC  = COEF_FRAC,
  parameter int M1    = S1_DECIM,
  parameter int TAPS1 = S1_TAPS,
  parameter int M2    = S2_DECIM,
  parameter int TAPS2 = S2_TAPS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic signed [W-1:0] s_i,
  input  logic signed [W-1:0] s_q,
  output logic                m_valid,
  input  logic                m_ready,
  output logic signed [W-1:0] m_i,
  output logic signed [W-1:0] m_q
);
  logic                accept, s1_valid, s2_valid;
  logic signed [W-1:0] s1_i, s1_q, s2_i, s2_q;

  // Whole chain stalls while an output waits; one output needs M1*M2 inputs,
  // so the held word is always gone before the next one is produced.
  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  polyphase_decim #(
    .M(M1), .TAPS(TAPS1), .W(W), .CW(CW), .FRAC(FRAC), .STAGE(1)
  ) stage1_i (
    .clk(clk), .rst(rst), .in_valid(accept), .in_i(s_i), .in_q(s_q),
    .out_valid(s1_valid), .out_i(s1_i), .out_q(s1_q)
  );

  polyphase_decim #(
    .M(M2), .TAPS(TAPS2), .W(W), .CW(CW), .FRAC(FRAC), .STAGE(2)
  ) stage2_i (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_i(s1_i), .in_q(s1_q),
    .out_valid(s2_valid), .out_i(s2_i), .out_q(s2_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
    end else if (s2_valid) begin
      m_valid <= 1'b1;
      m_i     <= s2_i;
      m_q     <= s2_q;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_decim32_chk.sv
module iq_decim32_chk #(
  parameter int W  = 16,
  parameter int M1 = 4,
  parameter int M2 = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                s_valid,
  input logic                s_ready,
  input logic                m_valid,
  input logic                m_ready,
  input logic signed [W-1:0] m_i,
  input logic signed [W-1:0] m_q,
  input logic                s1_valid,
  input logic                s2_valid
);
  logic [$clog2(M1)-1:0] cnt1;
  logic [$clog2(M2)-1:0] cnt2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt1 <= '0;
      cnt2 <= '0;
    end else begin
      if (s_valid && s_ready) cnt1 <= cnt1 + 1'b1;
      if (s1_valid)           cnt2 <= cnt2 + 1'b1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !m_valid && !s1_valid && !s2_valid);

  a_r2_stage1_phase: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> cnt1 == '0);

  a_r2_stage1_fires: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && cnt1 == ($clog2(M1))'(M1 - 1)) |=> s1_valid);

  a_r2_stage2_phase: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> cnt2 == '0);

  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> (!m_valid || m_ready));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid && $stable(m_i) && $stable(m_q));
endmodule

bind iq_decim32 iq_decim32_chk #(.W(W), .M1(M1), .M2(M2)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
  .s1_valid(s1_valid), .s2_valid(s2_valid)
);

// File: tb/iq_decim32_tb_top.sv
`timescale 1ns/1ps
module iq_decim32_tb_top;
  import decim_pkg::tap_coef;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic m_ready = 1'b0;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic s_ready, m_valid;
  logic signed [15:0] m_i, m_q;

  int n_chk = 0, n_fail = 0;
  int xi [1024];
  int xq [1024];
  int n_acc, n_out;
  bit hold_prev;
  logic signed [15:0] hold_i, hold_q;

  always #10 clk = ~clk;

  iq_decim32 dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .m_valid(m_valid), .m_ready(m_ready),
    .m_i(m_i), .m_q(m_q)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // R4 rounding and R5 saturation
  function automatic int rs(input longint a);
    longint r;
    r = (a + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int smp(input int ch, input int n);
    if (n < 0) return 0;
    return (ch == 0) ? xi[n] : xq[n];
  endfunction

  function automatic int ref1(input int ch, input int m);
    longint s = 0;
    if (m < 0) return 0;
    for (int j = 0; j < 16; j++) s += longint'(tap_coef(1, j)) * smp(ch, 4 * m + 3 - j);
    return rs(s);
  endfunction

  function automatic int ref2(input int ch, input int k);
    longint s = 0;
    for (int j = 0; j < 32; j++) s += longint'(tap_coef(2, j)) * ref1(ch, 8 * k + 7 - j);
    return rs(s);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; m_ready = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", int'(m_valid), 0, "m_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(m_valid), 0, "m_valid after reset");
    check("R1", int'(s_ready), 1, "s_ready after reset");
  endtask

  task automatic run_stream(input int n, input int gap, input int bp, input string req_i);
    int cyc = 0;
    int extra = 0;
    n_acc = 0; n_out = 0; hold_prev = 0;
    while ((n_acc < n || n_out < n / 32) && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (hold_prev) begin
        check("R8", int'(m_valid), 1, "valid held");
        check("R8", int'(m_i), int'(hold_i), "I held");
        check("R8", int'(m_q), int'(hold_q), "Q held");
      end
      s_valid = (n_acc < n) && ($urandom_range(99) >= gap);
      // R10: idle cycles carry garbage data
      s_i = s_valid ? 16'(xi[n_acc]) : 16'($urandom);
      s_q = s_valid ? 16'(xq[n_acc]) : 16'($urandom);
      m_ready = ($urandom_range(99) >= bp);
      #1;
      check("R7", int'(s_ready), int'(!m_valid || m_ready), "s_ready rule");
      if (m_valid && m_ready) begin
        check(req_i, int'(m_i), ref2(0, n_out), $sformatf("I out %0d", n_out));
        check("R6", int'(m_q), ref2(1, n_out), $sformatf("Q out %0d", n_out));
        check("R2", int'(n_acc >= 32 * n_out + 32), 1, "output after its 32 inputs");
        n_out++;
      end
      hold_prev = m_valid && !m_ready;
      hold_i = m_i; hold_q = m_q;
      if (s_valid && s_ready) n_acc++;
    end
    if (cyc >= 6000) check("R2", n_out, n / 32, "watchdog: stream hung");
    s_valid = 1'b0; m_ready = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      s_i = 16'($urandom); s_q = 16'($urandom);
      #1;
      if (m_valid) extra++;
    end
    check("R2", n_out + extra, n / 32, "output count");
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    do_reset();

    // impulse sweep over every block position: R4 (rounding of exact taps)
    for (int pos = 0; pos < 32; pos++) begin
      do_reset();
      for (int n = 0; n < 1024; n++) begin xi[n] = 0; xq[n] = 0; end
      xi[pos] = 32767;
      xi[pos + 64] = -12345;
      xq[(pos * 7 + 3) % 64] = -32768;
      run_stream(128, 20, 30, "R4");
    end

    // full-scale DC: R5
    do_reset();
    for (int n = 0; n < 1024; n++) begin xi[n] = 32767; xq[n] = -32768; end
    run_stream(256, 10, 10, "R5");

    // full-scale square wave, period 64: R5 in the second stage
    do_reset();
    for (int n = 0; n < 1024; n++) begin
      xi[n] = ((n / 32) % 2 == 0) ? 32767 : -32768;
      xq[n] = ((n / 32) % 2 == 0) ? -32768 : 32767;
    end
    run_stream(256, 0, 0, "R5");

    // random data, full rate then with gaps and stalls: R3, R10
    do_reset();
    for (int n = 0; n < 1024; n++) begin
      xi[n] = int'($urandom_range(65535)) - 32768;
      xq[n] = int'($urandom_range(65535)) - 32768;
    end
    run_stream(512, 0, 0, "R3");
    do_reset();
    run_stream(512, 50, 50, "R10");

    // mid-block reset with loaded accumulators: R9
    do_reset();
    run_stream(64, 0, 0, "R3");
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      s_valid = 1'b1; m_ready = 1'b1;
      s_i = 16'($urandom); s_q = 16'($urandom);
    end
    do_reset();
    for (int n = 0; n < 1024; n++) begin
      xi[n] = int'($urandom_range(20000)) - 10000;
      xq[n] = int'($urandom_range(65535)) - 32768;
    end
    run_stream(256, 25, 25, "R9");

    summary();
    $finish;
  end
endmodule